// File: doc/BRIEF.md
# Coherent Reset Sequencer

This block gathers reset requests from a set of hard and soft causes, decides which class of reset each one calls for, and drives a hard-reset and a soft-reset output. A request does not cut into a bus transfer. While a transfer is in flight the block holds the request, raises a bus-hold signal so that no new transfer begins, and drives reset only after the transfer reports its final beat. A transfer split into several beats for a narrow port counts as one unit. An access that the core breaks into independent transfers is protected only within each transfer, so reset may land in the gap between them.

A few internal causes are marked urgent. They skip the wait and drive reset on the next clock even in the middle of a transfer. Once driven, both outputs stay high for a fixed minimum number of clocks and then fall together. A sticky cause register keeps one bit per source. Software clears it by writing ones, and the power-on reset (`rst_n`) also clears it. `rst_n` returns the whole block to its idle state.

Top module: `coherent_rst_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `hard_rst`, `soft_rst` and `bus_hold` low and `cause_status` all zero.
- R2: With default parameters, sources 0 to 6 are hard causes and drive both `hard_rst` and `soft_rst`. Sources 7 to 9 are soft causes and drive only `soft_rst`. `hard_rst` is never high without `soft_rst`.
- R3: With no transfer in flight and no transfer starting, a request sampled at an edge drives reset in the very next cycle.
- R4: `bus_hold` is high in the cycle after a request is sampled while reset is low. It stays high until the reset outputs fall.
- R5: While a transfer is in flight, non-urgent reset waits through every beat. It rises in the cycle after the cycle in which `bus_beat` and `bus_last` are both high.
- R6: A transfer whose `bus_start` is sampled in the same cycle as the request is treated as in flight. A request sampled in an idle gap between two independent transfers drives reset at once.
- R7: Urgent sources (default: sources 1 and 2) drive reset in the cycle after they are sampled, even in the middle of a transfer.
- R8: If hard and soft requests are pending together, or a hard request arrives while a soft one waits, the reset driven is hard.
- R9: Once raised, the reset outputs stay high for exactly MIN_CYC cycles (default 16) and then fall in the same cycle.
- R10: A hard request sampled during an active soft-only reset raises `hard_rst` in the next cycle and restarts the MIN_CYC count from that cycle.
- R11: Each sampled request sets its bit in `cause_status`. The bit stays set until a write with `clr_we` high and a one in `clr_mask` at that bit. A request in the same cycle wins over the clear.
- R12: Any other request sampled while reset is active only sets its status bit. It neither changes the outputs nor extends the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| src_req | input | NSRC | One request line per reset source, sampled each clock |
| bus_start | input | 1 | Bus master begins a transfer this cycle |
| bus_beat | input | 1 | A data beat of the current transfer completes |
| bus_last | input | 1 | Qualifies `bus_beat` as the final beat of the transfer |
| clr_we | input | 1 | Write strobe for clearing status bits |
| clr_mask | input | NSRC | Ones select status bits to clear |
| bus_hold | output | 1 | No new transfer may start while high |
| hard_rst | output | 1 | Hard reset output, active high |
| soft_rst | output | 1 | Soft reset output, active high |
| cause_status | output | NSRC | Sticky per-source cause bits |

## Verification
The sequencing is driven with requests against an idle bus, against a four-beat split transfer, in the idle gap between two independent transfers, and in the same cycle as a new start. These show whether reset waits for the last beat and whether it respects transfer boundaries. Urgent sources fired mid-transfer separate the bypass path from the deferred path. Soft-then-hard patterns, both while waiting and during an active reset, show the priority and the count restart. A behavioural model is compared against the outputs and status every cycle, and directed checks pin the exact cycle of each edge and the length of the active window.

// File: rtl/rsq_pkg.sv
// Package rsq_pkg
// Shared types for the reset sequencer: the sequencer state and the
// per-cycle summary of sampled reset requests.
package rsq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_WAIT   = 2'd1,
        SEQ_ACTIVE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic any;   // at least one source requests this cycle
        logic hard;  // at least one hard-class source requests
        logic urg;   // at least one urgent (bypass) source requests
    } req_class_t;

endpackage

// File: rtl/rsq_classify.sv
// Module rsq_classify
// Sorts the raw source request vector into a class summary. A source is
// hard when its HARD_MASK bit is set, and soft otherwise. A source is urgent
// when its URG_MASK bit is set. Purely combinational.
// Assumes: request lines are already synchronous to clk.
module rsq_classify
    import rsq_pkg::*;
#(
    parameter int          NSRC      = 10,
    parameter logic [NSRC-1:0] HARD_MASK = '1,
    parameter logic [NSRC-1:0] URG_MASK  = '0
) (
    input  logic [NSRC-1:0] src_req,
    output req_class_t      cls
);

    logic [NSRC-1:0] hard_hit;
    logic [NSRC-1:0] urg_hit;

    // Per-source class match, one slice per source.
    for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
        assign hard_hit[gi] = src_req[gi] & HARD_MASK[gi];
        assign urg_hit[gi]  = src_req[gi] & URG_MASK[gi];
    end

    // Reduce the per-source matches into the class summary.
    always_comb begin
        cls.any  = |src_req;
        cls.hard = |hard_hit;
        cls.urg  = |urg_hit;
    end

endmodule

// File: rtl/rsq_bus_track.sv
// Module rsq_bus_track
// Tracks whether a bus transfer is in flight. A transfer opens on bus_start
// and closes on the beat flagged last, so all beats of a split access form
// one unit. The next-cycle view is offered combinationally so the sequencer
// can tell whether the bus is free after the current edge.
// Assumes: beats are only reported for an open transfer. A flush (reset being
// driven) abandons any open transfer.
module rsq_bus_track (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_start,
    input  logic bus_beat,
    input  logic bus_last,
    input  logic flush,
    output logic busy_q,
    output logic busy_nxt
);

    // Next in-flight state if no flush occurs.
    always_comb begin
        busy_nxt = (busy_q | bus_start) & ~(bus_beat & bus_last);
    end

    // In-flight register with flush on reset assertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (flush) begin
            busy_q <= 1'b0;
        end else begin
            busy_q <= busy_nxt;
        end
    end

endmodule

// File: rtl/rsq_status.sv
// Module rsq_status
// Sticky cause register. A sampled request sets its bit. A write-one clear
// drops bits, but a request in the same cycle keeps its bit set.
// Assumes: power-on reset (rst_n) clears all bits.
module rsq_status #(
    parameter int NSRC = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] status
);

    logic [NSRC-1:0] clr_eff;

    // Clear applies only with the write strobe.
    always_comb begin
        clr_eff = clr_we ? clr_mask : '0;
    end

    // Per-bit sticky update, set dominates clear.
    for (genvar gi = 0; gi < NSRC; gi++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status[gi] <= 1'b0;
            end else if (src_req[gi]) begin
                status[gi] <= 1'b1;
            end else if (clr_eff[gi]) begin
                status[gi] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rsq_seq.sv
// Module rsq_seq
// Reset sequencing state machine. From idle, a request either drives reset
// at once (bus free after this edge, or an urgent source) or waits with the
// bus held. While waiting, hard requests upgrade the pending class. While
// active, the outputs hold for MIN_CYC cycles. A late hard request upgrades a
// soft-only reset and restarts the count. Other late requests are dropped
// here (the status register still records them).
// Assumes: busy_nxt is the bus tracker's next-cycle view without flush.
module rsq_seq
    import rsq_pkg::*;
#(
    parameter int MIN_CYC = 16,
    localparam int CNT_W  = (MIN_CYC > 1) ? $clog2(MIN_CYC) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  req_class_t cls,
    input  logic       busy_nxt,
    output logic       hard_o,
    output logic       soft_o,
    output logic       hold_o,
    output logic       flush_o
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MIN_CYC - 1);

    seq_state_e       state_q, state_d;
    logic             pend_hard_q, pend_hard_d;
    logic             hard_q, hard_d;
    logic             soft_q, soft_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             go_active;
    logic             hard_now;

    // Next-state, class and count decisions for one clock.
    always_comb begin
        state_d     = state_q;
        pend_hard_d = pend_hard_q;
        hard_d      = hard_q;
        soft_d      = soft_q;
        cnt_d       = cnt_q;
        go_active   = 1'b0;
        hard_now    = pend_hard_q | cls.hard;
        unique case (state_q)
            SEQ_IDLE, SEQ_WAIT: begin
                if (cls.any || state_q == SEQ_WAIT) begin
                    if (cls.urg || !busy_nxt) begin
                        go_active   = 1'b1;
                        state_d     = SEQ_ACTIVE;
                        hard_d      = hard_now;
                        soft_d      = 1'b1;
                        cnt_d       = CNT_LOAD;
                        pend_hard_d = 1'b0;
                    end else begin
                        state_d     = SEQ_WAIT;
                        pend_hard_d = hard_now;
                    end
                end
            end
            SEQ_ACTIVE: begin
                if (cls.hard && !hard_q) begin
                    hard_d = 1'b1;
                    cnt_d  = CNT_LOAD;
                end else if (cnt_q == '0) begin
                    state_d = SEQ_IDLE;
                    hard_d  = 1'b0;
                    soft_d  = 1'b0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = SEQ_IDLE;
            end
        endcase
    end

    // Sequencer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SEQ_IDLE;
            pend_hard_q <= 1'b0;
            hard_q      <= 1'b0;
            soft_q      <= 1'b0;
            cnt_q       <= '0;
        end else begin
            state_q     <= state_d;
            pend_hard_q <= pend_hard_d;
            hard_q      <= hard_d;
            soft_q      <= soft_d;
            cnt_q       <= cnt_d;
        end
    end

    // Output mapping: hold whenever not idle, flush bus tracking under reset.
    always_comb begin
        hard_o  = hard_q;
        soft_o  = soft_q;
        hold_o  = (state_q != SEQ_IDLE);
        flush_o = go_active | (state_q == SEQ_ACTIVE);
    end

endmodule

// File: rtl/coherent_rst_seq.sv
// Module coherent_rst_seq
// Top of the coherent reset sequencer. It wires the source classifier, the
// bus transfer tracker, the reset state machine and the sticky cause register.
// Assumes: all inputs are synchronous to clk. rst_n is the power-on reset.
module coherent_rst_seq
    import rsq_pkg::*;
#(
    parameter int              NSRC      = 10,
    parameter logic [NSRC-1:0] HARD_MASK = 10'b00_0111_1111,
    parameter logic [NSRC-1:0] URG_MASK  = 10'b00_0000_0110,
    parameter int              MIN_CYC   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic            bus_start,
    input  logic            bus_beat,
    input  logic            bus_last,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_mask,
    output logic            bus_hold,
    output logic            hard_rst,
    output logic            soft_rst,
    output logic [NSRC-1:0] cause_status
);

    req_class_t cls;
    logic       busy_q;
    logic       busy_nxt;
    logic       flush;

    rsq_classify #(
        .NSRC      (NSRC),
        .HARD_MASK (HARD_MASK),
        .URG_MASK  (URG_MASK)
    ) u_classify (
        .src_req (src_req),
        .cls     (cls)
    );

    rsq_bus_track u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_beat  (bus_beat),
        .bus_last  (bus_last),
        .flush     (flush),
        .busy_q    (busy_q),
        .busy_nxt  (busy_nxt)
    );

    rsq_seq #(
        .MIN_CYC (MIN_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cls      (cls),
        .busy_nxt (busy_nxt),
        .hard_o   (hard_rst),
        .soft_o   (soft_rst),
        .hold_o   (bus_hold),
        .flush_o  (flush)
    );

    rsq_status #(
        .NSRC (NSRC)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (src_req),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .status   (cause_status)
    );

endmodule

// File: rtl/rsq_chk.sv
// Module rsq_chk
// Property checker for coherent_rst_seq, attached by bind. It keeps its own
// view of the open transfer and of the length of the reset window, built
// from the top-level ports only.
module rsq_chk #(
    parameter int              NSRC     = 10,
    parameter logic [NSRC-1:0] URG_MASK = '0,
    parameter int              MIN_CYC  = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_req,
    input logic            bus_start,
    input logic            bus_beat,
    input logic            bus_last,
    input logic            bus_hold,
    input logic            hard_rst,
    input logic            soft_rst,
    input logic [NSRC-1:0] cause_status
);

    logic xfer_q;
    logic hard_d;
    int   run_len;

    // Checker-side transfer tracking and reset window length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_q  <= 1'b0;
            hard_d  <= 1'b0;
            run_len <= 0;
        end else begin
            xfer_q  <= soft_rst ? 1'b0 : ((xfer_q | bus_start) & ~(bus_beat & bus_last));
            hard_d  <= hard_rst;
            run_len <= !soft_rst ? 0 : ((hard_rst && !hard_d) ? 1 : run_len + 1);
        end
    end

    // R1
    por_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (cause_status == '0 && !soft_rst && !hard_rst && !bus_hold));

    // R2
    hard_implies_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hard_rst |-> soft_rst);

    // R4
    hold_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_req != '0) && !soft_rst) |=> bus_hold);

    // R4
    hold_during_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> bus_hold);

    // R5
    no_mid_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && (xfer_q || bus_start) && !(bus_beat && bus_last)
         && ((src_req & URG_MASK) == '0)) |=> !soft_rst);

    // R7
    urgent_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((src_req & URG_MASK) != '0) && !soft_rst) |=> soft_rst);

    // R9
    window_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_rst) |-> (run_len == MIN_CYC && !hard_rst));

    // R11
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req != '0) |=> ((cause_status & $past(src_req)) == $past(src_req)));

endmodule

bind coherent_rst_seq rsq_chk #(
    .NSRC     (NSRC),
    .URG_MASK (URG_MASK),
    .MIN_CYC  (MIN_CYC)
) u_rsq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_req      (src_req),
    .bus_start    (bus_start),
    .bus_beat     (bus_beat),
    .bus_last     (bus_last),
    .bus_hold     (bus_hold),
    .hard_rst     (hard_rst),
    .soft_rst     (soft_rst),
    .cause_status (cause_status)
);

// File: tb/test_coherent_rst_seq.sv
// Bench for coherent_rst_seq: a behavioural reference compared every clock,
// plus directed checks on the exact cycle of each reset edge.
module test_coherent_rst_seq;

    localparam int              NSRC = 10;
    localparam logic [NSRC-1:0] HMSK = 10'b00_0111_1111;
    localparam logic [NSRC-1:0] UMSK = 10'b00_0000_0110;
    localparam int              MINC = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_req = '0;
    logic            bus_start = 1'b0;
    logic            bus_beat = 1'b0;
    logic            bus_last = 1'b0;
    logic            clr_we = 1'b0;
    logic [NSRC-1:0] clr_mask = '0;
    logic            bus_hold;
    logic            hard_rst;
    logic            soft_rst;
    logic [NSRC-1:0] cause_status;

    int errors = 0;
    int checks = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    coherent_rst_seq i_coherent_rst_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_req      (src_req),
        .bus_start    (bus_start),
        .bus_beat     (bus_beat),
        .bus_last     (bus_last),
        .clr_we       (clr_we),
        .clr_mask     (clr_mask),
        .bus_hold     (bus_hold),
        .hard_rst     (hard_rst),
        .soft_rst     (soft_rst),
        .cause_status (cause_status)
    );

    // Behavioural reference: mode 0 idle, 1 waiting, 2 driving reset.
    int              m_mode;
    int              m_left;
    bit              m_busy, m_ph, m_hard, m_soft;
    logic [NSRC-1:0] m_stat;
    bit              t_any, t_hard, t_urg, t_free_not, t_go, t_was_act;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_busy = 0; m_ph = 0;
            m_hard = 0; m_soft = 0; m_stat = '0;
        end else begin
            t_any      = (src_req != '0);
            t_hard     = ((src_req & HMSK) != '0);
            t_urg      = ((src_req & UMSK) != '0);
            t_free_not = (m_busy || bus_start) && !(bus_beat && bus_last);
            t_was_act  = (m_mode == 2);
            t_go       = 0;
            m_stat     = (m_stat & ~(clr_we ? clr_mask : '0)) | src_req;
            if (m_mode == 2) begin
                if (t_hard && !m_hard) begin
                    m_hard = 1; m_left = MINC;
                end else begin
                    m_left = m_left - 1;
                    if (m_left == 0) begin
                        m_mode = 0; m_hard = 0; m_soft = 0;
                    end
                end
            end else if (t_any || m_mode == 1) begin
                if (t_urg || !t_free_not) begin
                    m_hard = m_ph || t_hard; m_soft = 1;
                    m_mode = 2; m_left = MINC; m_ph = 0; t_go = 1;
                end else begin
                    m_ph = m_ph || t_hard; m_mode = 1;
                end
            end
            m_busy = (t_go || t_was_act) ? 1'b0 : t_free_not;
        end
    end

    // Every-cycle comparison against the reference, away from the edge.
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            checks++;
            if ({hard_rst, soft_rst, bus_hold, cause_status} !==
                {m_hard, m_soft, (m_mode != 0), m_stat}) begin
                errors++;
                $display("FAIL R2 R3 R5 model compare t=%0t act=%b/%b/%b/%h exp=%b/%b/%b/%h",
                         $time, hard_rst, soft_rst, bus_hold, cause_status,
                         m_hard, m_soft, (m_mode != 0), m_stat);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Apply one cycle of stimulus at a falling edge, return at the next one.
    task automatic drive(input logic [NSRC-1:0] s, input logic st,
                         input logic bt, input logic ls);
        src_req = s; bus_start = st; bus_beat = bt; bus_last = ls;
        @(negedge clk);
    endtask

    // Count remaining cycles with reset high, idling the inputs.
    task automatic run_out(output int n);
        n = 0;
        while (soft_rst && n < 1000) begin
            n++;
            drive('0, 0, 0, 0);
        end
    endtask

    function automatic logic [NSRC-1:0] bit_of(input int i);
        return NSRC'(1) << i;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired act=running exp=finished");
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs", {29'd0, hard_rst, soft_rst, bus_hold}, 32'd0);
        chk("R1 status", 32'(cause_status), 32'd0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);

        // R3 R2 R9: soft source on idle bus
        drive(bit_of(7), 0, 0, 0);
        chk("R3 idle soft rises next", 32'(soft_rst), 32'd1);
        chk("R2 soft source leaves hard low", 32'(hard_rst), 32'd0);
        chk("R4 hold with reset", 32'(bus_hold), 32'd1);
        run_out(n);
        chk("R9 window length", 32'(n), 32'(MINC));
        chk("R11 sticky bit 7", 32'(cause_status), 32'h080);
        clr_we = 1'b1; clr_mask = bit_of(7);
        drive('0, 0, 0, 0);
        clr_we = 1'b0; clr_mask = '0;
        chk("R11 write-one clear", 32'(cause_status), 32'd0);

        // R5 R4: hard request during a four-beat split transfer
        drive('0, 1, 0, 0);
        drive(bit_of(0), 0, 1, 0);
        chk("R4 hold after request", 32'(bus_hold), 32'd1);
        chk("R5 no reset at beat 1", 32'(soft_rst), 32'd0);
        drive('0, 0, 1, 0);
        chk("R5 no reset at beat 2", 32'(soft_rst), 32'd0);
        drive('0, 0, 1, 0);
        chk("R5 no reset at beat 3", 32'(soft_rst), 32'd0);
        drive('0, 0, 1, 1);
        chk("R5 reset after last beat", {30'd0, hard_rst, soft_rst}, 32'd3);
        run_out(n);
        chk("R9 window after split", 32'(n), 32'(MINC));

        // R7: urgent source mid transfer
        drive('0, 1, 0, 0);
        drive('0, 0, 1, 0);
        drive(bit_of(1), 0, 1, 0);
        chk("R7 urgent bypass", {30'd0, hard_rst, soft_rst}, 32'd3);
        run_out(n);

        // R8: soft then hard while waiting
        drive('0, 1, 0, 0);
        drive(bit_of(8), 0, 1, 0);
        drive(bit_of(3), 0, 1, 0);
        chk("R8 still waiting", 32'(soft_rst), 32'd0);
        drive('0, 0, 1, 1);
        chk("R8 upgraded to hard", {30'd0, hard_rst, soft_rst}, 32'd3);
        run_out(n);
        // R8: simultaneous hard and soft on idle bus
        drive(bit_of(6) | bit_of(7), 0, 0, 0);
        chk("R8 simultaneous picks hard", 32'(hard_rst), 32'd1);
        run_out(n);

        // R10 R12: hard upgrade during soft reset, then ignored requests
        drive(bit_of(9), 0, 0, 0);
        repeat (4) drive('0, 0, 0, 0);
        chk("R10 soft only before upgrade", {30'd0, hard_rst, soft_rst}, 32'd1);
        drive(bit_of(4), 0, 0, 0);
        chk("R10 hard rises next cycle", 32'(hard_rst), 32'd1);
        clr_we = 1'b1; clr_mask = bit_of(5);
        drive(bit_of(5) | bit_of(8), 0, 0, 0);
        clr_we = 1'b0; clr_mask = '0;
        chk("R11 set wins over clear", 32'(cause_status[5]), 32'd1);
        run_out(n);
        chk("R12 late request does not extend", 32'(n), 32'(MINC - 1));
        chk("R10 R12 both fell", {30'd0, hard_rst, soft_rst}, 32'd0);

        // R6: gap between independent transfers, and same-cycle start
        drive('0, 1, 0, 0);
        drive('0, 0, 1, 1);
        drive(bit_of(9), 0, 0, 0);
        chk("R6 reset in gap", 32'(soft_rst), 32'd1);
        run_out(n);
        drive(bit_of(9), 1, 0, 0);
        chk("R6 same-cycle start honoured", {30'd0, bus_hold, soft_rst}, 32'd2);
        drive('0, 0, 1, 1);
        chk("R6 reset after that transfer", 32'(soft_rst), 32'd1);
        run_out(n);

        // R1: power-on reset clears sticky status
        rst_n = 1'b0;
        drive('0, 0, 0, 0);
        chk("R1 status cleared by power-on", 32'(cause_status), 32'd0);
        rst_n = 1'b1;
        drive('0, 0, 0, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule